// File: doc/BRIEF.md
# Dual-Input Decade Up/Down Counter

This block holds one decimal digit (0 to 9) in a 4-bit register and moves it up or down in response to two separate count inputs. A rising edge on the up input adds one; a rising edge on the down input subtracts one. Both inputs are level signals from outside the system-clock domain. Each passes through a synchronizer and an edge detector, and the digit register is updated on the system clock.

A preset port with an active-low load strobe and an active-high clear act at once on the visible digit. They override the register combinationally and are also captured on the next clock edge. Two active-low terminal-count outputs flag the top and bottom of the decade while the matching count input is low. Because of this, the rising edge at the end of each flag pulse can serve as the count input of the next digit. The six codes above 9 are never produced by counting, but they can be loaded. Counting from them follows fixed recovery paths back into the decade.

Top module: `bcd_dualclk_counter`

## Requirements
- R1: A rising edge on `cnt_up_i` while `cnt_dn_i` is high raises the digit by one, and 9 steps to 0.
- R2: A rising edge on `cnt_dn_i` while `cnt_up_i` is high lowers the digit by one, and 0 steps to 9.
- R3: While `load_n_i` is low and `clr_i` is low, `digit_o` equals `preset_i` in the same cycle and count edges have no effect. The register keeps that value after `load_n_i` returns high.
- R4: While `clr_i` is high, `digit_o` is 0 whatever `load_n_i`, `preset_i` and the count inputs do. Clear wins over load.
- R5: Counting up from codes above 9 gives 10→11→6, 12→13→4 and 14→15→2.
- R6: Counting down from codes above 9 gives 15→14→13→12→11→10→9.
- R7: `carry_n_o` is 0 exactly when digit bit 0 and bit 3 are both 1 and the synchronized up input is low. Otherwise it is 1.
- R8: `borrow_n_o` is 0 exactly when the digit is 0 and the synchronized down input is low. Otherwise it is 1.
- R9: The digit holds if both inputs rise in the same system-clock cycle. It also holds if one input rises while the other is low.
- R10: With `SYNC_STAGES` = 2, a rising edge on a count input changes `digit_o` at the third rising `clk` edge after it. Two edges later the digit is still unchanged.
- R11: When one stage's `carry_n_o` drives the next stage's `cnt_up_i`, and its `borrow_n_o` drives the next stage's `cnt_dn_i`, two stages count 00 to 99 and back without a missed or extra step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the count inputs |
| rst_n | input | 1 | Active-low system reset; digit 0, count inputs taken as idle high |
| cnt_up_i | input | 1 | Up count input, acts on its rising edge |
| cnt_dn_i | input | 1 | Down count input, acts on its rising edge |
| clr_i | input | 1 | Active-high master clear |
| load_n_i | input | 1 | Active-low parallel load strobe |
| preset_i | input | 4 | Value loaded while `load_n_i` is low |
| digit_o | output | 4 | Current digit, with clear and load applied at once |
| carry_n_o | output | 1 | Active-low top-of-decade flag for cascading upward |
| borrow_n_o | output | 1 | Active-low bottom-of-decade flag for cascading downward |

## Verification
The bench builds the counter with the default two-stage synchronizer. This fixes the input-to-digit latency at three clock edges, so the bench can sample just before and just after the change to check R10. The bench also places a second instance with the same defaults behind the first, wired through the terminal-count outputs. With the synchronizer and edge detector of both stages in the path, a full 00-to-99-and-back run is short enough to compare every intermediate value against a model.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;

  // next code when stepping up; codes above 9 use fixed recovery paths
  function automatic digit_t bcd_inc(input digit_t v);
    case (v)
      4'd9:    bcd_inc = 4'd0;
      4'd11:   bcd_inc = 4'd6;
      4'd13:   bcd_inc = 4'd4;
      4'd15:   bcd_inc = 4'd2;
      default: bcd_inc = v + 4'd1;
    endcase
  endfunction

  // next code when stepping down; 0 wraps to 9, all others simply decrement
  function automatic digit_t bcd_dec(input digit_t v);
    bcd_dec = (v == 4'd0) ? 4'd9 : v - 4'd1;
  endfunction
endpackage

// File: rtl/cnt_in_sync.sv
module cnt_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic          prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '1;
        else        chain_q <= async_i;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[LAST-1:0], async_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[LAST];

  assign level_o = chain_q[LAST];
  assign rise_o  = chain_q[LAST] & ~prev_q;

  // a rise is one cycle wide: never two cycles running
  p_rise_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/bcd_digit_reg.sv
module bcd_digit_reg
  import bcd_cnt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   up_lvl,
  input  logic   dn_lvl,
  input  logic   up_rise,
  input  logic   dn_rise,
  input  logic   clr_i,
  input  logic   load_n_i,
  input  digit_t preset_i,
  output digit_t digit_o
);
  digit_t count_q;
  logic   step_up, step_dn, ovr_clr, ovr_load;

  // an edge counts only alone and only while the other input rests high
  assign step_up  = up_rise & ~dn_rise & dn_lvl;
  assign step_dn  = dn_rise & ~up_rise & up_lvl;
  assign ovr_clr  = clr_i;
  assign ovr_load = ~clr_i & ~load_n_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        count_q <= '0;
    else if (ovr_clr)  count_q <= '0;
    else if (ovr_load) count_q <= preset_i;
    else if (step_up)  count_q <= bcd_inc(count_q);
    else if (step_dn)  count_q <= bcd_dec(count_q);

  always_comb begin
    if (ovr_clr)       digit_o = '0;
    else if (ovr_load) digit_o = preset_i;
    else               digit_o = count_q;
  end

  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> count_q == '0);
  p_load_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !load_n_i) |=> count_q == $past(preset_i));
  p_up_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !clr_i && load_n_i && count_q < 4'd9) |=> count_q == $past(count_q) + 4'd1);
  p_dn_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !clr_i && load_n_i && count_q != 4'd0) |=> count_q == $past(count_q) - 4'd1);
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_up && !step_dn && !clr_i && load_n_i) |=> $stable(count_q));
endmodule

// File: rtl/term_count_gen.sv
module term_count_gen
  import bcd_cnt_pkg::*;
(
  input  digit_t digit_i,
  input  logic   up_lvl,
  input  logic   dn_lvl,
  output logic   carry_n_o,
  output logic   borrow_n_o
);
  assign carry_n_o  = ~(digit_i[0] & digit_i[3] & ~up_lvl);
  assign borrow_n_o = ~((digit_i == '0) & ~dn_lvl);
endmodule

// File: rtl/bcd_dualclk_counter.sv
module bcd_dualclk_counter
  import bcd_cnt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_up_i,
  input  logic       cnt_dn_i,
  input  logic       clr_i,
  input  logic       load_n_i,
  input  logic [3:0] preset_i,
  output logic [3:0] digit_o,
  output logic       carry_n_o,
  output logic       borrow_n_o
);
  logic up_lvl, up_rise, dn_lvl, dn_rise;

  cnt_in_sync #(.STAGES(SYNC_STAGES)) up_sync_i (
    .clk(clk), .rst_n(rst_n), .async_i(cnt_up_i), .level_o(up_lvl), .rise_o(up_rise));
  cnt_in_sync #(.STAGES(SYNC_STAGES)) dn_sync_i (
    .clk(clk), .rst_n(rst_n), .async_i(cnt_dn_i), .level_o(dn_lvl), .rise_o(dn_rise));

  bcd_digit_reg digit_i (
    .clk(clk), .rst_n(rst_n), .up_lvl(up_lvl), .dn_lvl(dn_lvl),
    .up_rise(up_rise), .dn_rise(dn_rise), .clr_i(clr_i), .load_n_i(load_n_i),
    .preset_i(preset_i), .digit_o(digit_o));

  term_count_gen tc_i (
    .digit_i(digit_o), .up_lvl(up_lvl), .dn_lvl(dn_lvl),
    .carry_n_o(carry_n_o), .borrow_n_o(borrow_n_o));

  p_carry_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n_o |-> (digit_o[0] && digit_o[3] && !up_lvl));
  p_borrow_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n_o |-> (digit_o == 4'd0 && !dn_lvl));
  p_clear_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |-> (digit_o == 4'd0 && borrow_n_o == !(!dn_lvl)));
endmodule

// File: tb/bcd_dualclk_counter_tb_top.sv
module bcd_dualclk_counter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up = 1'b1, dn = 1'b1, clr = 1'b0, load_n = 1'b1;
  logic [3:0] pre = 4'd0;
  logic [3:0] dig;
  logic carry_n, borrow_n;
  logic hi_clr = 1'b0;
  logic [3:0] hi_dig;
  logic hi_carry_n, hi_borrow_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bcd_dualclk_counter dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_up_i(up), .cnt_dn_i(dn), .clr_i(clr),
    .load_n_i(load_n), .preset_i(pre), .digit_o(dig),
    .carry_n_o(carry_n), .borrow_n_o(borrow_n));

  bcd_dualclk_counter hi_i (
    .clk(clk), .rst_n(rst_n), .cnt_up_i(carry_n), .cnt_dn_i(borrow_n), .clr_i(hi_clr),
    .load_n_i(1'b1), .preset_i(4'd0), .digit_o(hi_dig),
    .carry_n_o(hi_carry_n), .borrow_n_o(hi_borrow_n));

  // op: 0 load, 1 up, 2 down, 3 clear ; {op, data, expected}
  localparam int NV = 24;
  localparam logic [9:0] VEC [NV] = '{
    {2'd0, 4'd10, 4'd10}, {2'd1, 4'd0, 4'd11}, {2'd1, 4'd0, 4'd6},
    {2'd0, 4'd12, 4'd12}, {2'd1, 4'd0, 4'd13}, {2'd1, 4'd0, 4'd4},
    {2'd0, 4'd14, 4'd14}, {2'd1, 4'd0, 4'd15}, {2'd1, 4'd0, 4'd2},
    {2'd0, 4'd15, 4'd15}, {2'd2, 4'd0, 4'd14}, {2'd2, 4'd0, 4'd13},
    {2'd2, 4'd0, 4'd12}, {2'd2, 4'd0, 4'd11}, {2'd2, 4'd0, 4'd10},
    {2'd2, 4'd0, 4'd9},  {2'd0, 4'd9, 4'd9},   {2'd1, 4'd0, 4'd0},
    {2'd2, 4'd0, 4'd9},  {2'd0, 4'd0, 4'd0},   {2'd2, 4'd0, 4'd9},
    {2'd1, 4'd0, 4'd0},  {2'd1, 4'd0, 4'd1},   {2'd3, 4'd0, 4'd0}};

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_up();
    up = 1'b0; cycles(5); up = 1'b1; cycles(9);
  endtask

  task automatic pulse_dn();
    dn = 1'b0; cycles(5); dn = 1'b1; cycles(9);
  endtask

  task automatic do_load(input logic [3:0] v);
    pre = v; load_n = 1'b0; cycles(1); load_n = 1'b1; cycles(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] prev;
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    check("R4 reset digit", dig, 0);
    check("R7 reset carry", carry_n, 1);
    check("R8 reset borrow", borrow_n, 1);

    // vector walk
    prev = 4'd0;
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][9:8])
        2'd0: begin do_load(VEC[i][7:4]); check("R3 table load", dig, VEC[i][3:0]); end
        2'd1: begin
          pulse_up();
          if (prev > 4'd9) check("R5 table up", dig, VEC[i][3:0]);
          else             check("R1 table up", dig, VEC[i][3:0]);
        end
        2'd2: begin
          pulse_dn();
          if (prev > 4'd9) check("R6 table down", dig, VEC[i][3:0]);
          else             check("R2 table down", dig, VEC[i][3:0]);
        end
        default: begin clr = 1'b1; cycles(1); clr = 1'b0; cycles(1);
          check("R4 table clear", dig, VEC[i][3:0]); end
      endcase
      prev = VEC[i][3:0];
    end

    // immediate load, count edges ignored during load
    pre = 4'd7; load_n = 1'b0; #1;
    check("R3 load immediate", dig, 7);
    cycles(1);
    up = 1'b0; cycles(4); up = 1'b1; cycles(6);
    check("R3 edge ignored under load", dig, 7);
    load_n = 1'b1; cycles(2);
    check("R3 value kept after load", dig, 7);

    // clear priority over load
    pre = 4'd5; load_n = 1'b0; clr = 1'b1; #1;
    check("R4 clear beats load", dig, 0);
    cycles(2);
    check("R4 clear held", dig, 0);
    clr = 1'b0; load_n = 1'b1; cycles(2);
    check("R4 after clear", dig, 0);

    // simultaneous rise holds
    do_load(4'd4);
    up = 1'b0; dn = 1'b0; cycles(5);
    up = 1'b1; dn = 1'b1; cycles(8);
    check("R9 both rise hold", dig, 4);
    // up rises while down is low
    dn = 1'b0; cycles(4);
    pulse_up();
    check("R9 up edge while down low", dig, 4);
    dn = 1'b1; cycles(8);
    check("R2 down release counts", dig, 3);

    // latency
    do_load(4'd2);
    up = 1'b0; cycles(5);
    up = 1'b1; cycles(2);
    check("R10 unchanged after two edges", dig, 2);
    cycles(1);
    check("R10 changed on third edge", dig, 3);
    cycles(5);

    // terminal counts
    do_load(4'd9);
    up = 1'b0; cycles(4);
    check("R7 carry low at 9", carry_n, 0);
    up = 1'b1; cycles(2);
    check("R7 carry released on up rise", carry_n, 1);
    cycles(6);
    do_load(4'd8);
    up = 1'b0; cycles(4);
    check("R7 carry high at 8", carry_n, 1);
    up = 1'b1; cycles(8);
    do_load(4'd0);
    dn = 1'b0; cycles(4);
    check("R8 borrow low at 0", borrow_n, 0);
    load_n = 1'b0; pre = 4'd1; #1;
    check("R8 borrow high at 1", borrow_n, 1);
    cycles(1); load_n = 1'b1;
    dn = 1'b1; cycles(8);

    // two-digit cascade
    clr = 1'b1; hi_clr = 1'b1; cycles(2); clr = 1'b0; hi_clr = 1'b0; cycles(4);
    check("R11 cascade start", {hi_dig, dig}, 0);
    for (int v = 1; v <= 99; v++) begin
      pulse_up();
      check("R11 cascade up", hi_dig * 10 + dig, v);
    end
    for (int v = 98; v >= 0; v--) begin
      pulse_dn();
      check("R11 cascade down", hi_dig * 10 + dig, v);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule